// File: doc/BRIEF.md
# Iterative Bit Permutation Engine

This block applies any fixed permutation of the bits of a W-bit word. Software-style
configuration gives the permutation as log2(W) control words. Control word k carries,
at bit position b, bit k of the destination index of source bit b. Word 0 holds the
least significant index bits. After loading, a start pulse runs a one-time
conditioning pass. That pass rewrites each control word by grouping it against every
lower-numbered word. The conditioned words then act as stage masks.

Every data word then goes through log2(W) group steps, one per clock. Each step uses
the next stage mask in ascending order. A group step takes the data bits where the mask
is 1 and packs them, in their original order, into the top of the result. It packs the
remaining bits, also in order, into the bottom. The sequence works like a stable radix
sort of the bits by destination index.

Both the data input and the result output are valid/ready streams. A word is taken
when `in_valid` and `in_ready` are both high at a clock edge. A result is offered on
`out_valid` and held with `out_data` unchanged until `out_ready` is seen high at an
edge. While a result waits, no new word is accepted. Configuration pins are plain
strobes. They act only while `busy` is low, and in that cycle they take priority over a
data handshake.

Top module: `perm_engine`

## Requirements
- R1: After reset `busy`, `in_ready` and `out_valid` are low. `in_ready` stays low until a conditioning pass has completed.
- R2: A `cfg_we` pulse while `busy` is low stores `cfg_word` as control word `cfg_sel` (0 to log2(W)-1). Bit b of word k is bit k of source bit b's destination index.
- R3: A `cfg_go` pulse while `busy` is low starts conditioning. `busy` is then high for exactly log2(W)*(log2(W)-1)/2 cycles (10 for W=32), and `in_ready` stays low throughout. Afterwards `busy` falls and `in_ready` rises.
- R4: For an accepted word, `out_data` bit d[b] equals input bit b, where d[b] is source bit b's destination index from the loaded control words.
- R5: `out_valid` rises exactly log2(W) cycles after the acceptance edge (5 for W=32). The stage masks are reused for every word without a new conditioning pass.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. From acceptance until the result is taken, `in_ready` is low and `busy` is high. Each accepted word yields exactly one output transfer.
- R7: `cfg_we` and `cfg_go` while `busy` is high are ignored. The current result and later results still follow the old permutation.
- R8: With control words 0x07137FE0, 0x6BD9232C, 0xDD230F1C, 0x63665639, 0xA5A435AE, the result equals five group steps with masks 0x07137FE0, 0x75196E8C, 0x56A3CCE4, 0xAA539AC9, 0x96665A69, in that order. Group(v,m) places the bits of v under the 1s of m, in order, above the bits under the 0s.
- R9: A `cfg_we` while idle invalidates the stage masks. `in_ready` is low from the next cycle until a new conditioning pass completes, and a held `in_valid` is not accepted in that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a control word |
| cfg_sel | input | log2(W) | Index of the control word being written |
| cfg_word | input | W | Control word value |
| cfg_go | input | 1 | Start the conditioning pass |
| busy | output | 1 | High while conditioning, computing or holding a result |
| in_valid | input | 1 | Data input valid |
| in_ready | output | 1 | Data input can be accepted |
| in_data | input | W | Word to permute |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | W | Permuted word |

## Verification
The hardest situation to reach is a configuration strobe that arrives while the engine
is mid-way through conditioning or holding an unaccepted result. That strobe must leave
both the stage masks and the result untouched. The stimulus fires garbage writes and
start pulses in exactly those windows, with `out_ready` held low to stretch the hold
state. It then permutes further words and compares them with the old permutation.
Random permutations built by shuffling destination indices are checked against a
direct index-mapped model. A published set of control words is checked against an
independent chain of group steps using its known conditioned masks.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_RUN  = 2'd2,
    ST_OUT  = 2'd3
  } perm_state_e;
endpackage

// File: rtl/pext_unit.sv
module pext_unit #(
  parameter int W  = 32,
  parameter int LW = $clog2(W),
  parameter int CW = LW + 1
) (
  input  logic [W-1:0]  src,
  input  logic [W-1:0]  sel,
  output logic [W-1:0]  packed_o,
  output logic [CW-1:0] count_o
);
  // compact the selected bits of src toward bit 0, keeping their order
  always_comb begin
    packed_o = '0;
    count_o  = '0;
    for (int b = 0; b < W; b++) begin
      if (sel[b]) begin
        packed_o[count_o[LW-1:0]] = src[b];
        count_o = count_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/grp_unit.sv
module grp_unit #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] msk,
  output logic [W-1:0] grouped
);
  localparam int LW = $clog2(W);
  localparam int CW = LW + 1;

  logic [W-1:0]  part [2];
  logic [CW-1:0] cnt  [2];

  // half 0 gathers the bits under mask zeros, half 1 the bits under mask ones
  for (genvar h = 0; h < 2; h++) begin : g_half
    pext_unit #(.W(W)) u_pext (
      .src      (val),
      .sel      ((h == 1) ? msk : ~msk),
      .packed_o (part[h]),
      .count_o  (cnt[h])
    );
  end

  assign grouped = (part[1] << cnt[0]) | part[0];
endmodule

// File: rtl/perm_ctrl.sv
module perm_ctrl
  import perm_pkg::*;
#(
  parameter int W  = 32,
  parameter int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_go,
  input  logic          in_valid,
  input  logic          out_ready,
  output perm_state_e   st,
  output logic [LW-1:0] pi,
  output logic [LW-1:0] pj,
  output logic [LW-1:0] step,
  output logic          masks_ok
);
  localparam logic [LW-1:0] LAST = LW'(LW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      pi       <= '0;
      pj       <= '0;
      step     <= '0;
      masks_ok <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (cfg_go) begin
            st       <= ST_PREP;
            pi       <= LW'(1);
            pj       <= '0;
            masks_ok <= 1'b0;
          end else if (cfg_we) begin
            masks_ok <= 1'b0;
          end else if (in_valid && masks_ok) begin
            st   <= ST_RUN;
            step <= '0;
          end
        end
        ST_PREP: begin
          if (pj == pi - 1'b1) begin
            pj <= '0;
            if (pi == LAST) begin
              st       <= ST_IDLE;
              masks_ok <= 1'b1;
            end else begin
              pi <= pi + 1'b1;
            end
          end else begin
            pj <= pj + 1'b1;
          end
        end
        ST_RUN: begin
          if (step == LAST) st <= ST_OUT;
          else              step <= step + 1'b1;
        end
        ST_OUT: begin
          if (out_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/perm_engine.sv
module perm_engine
  import perm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [$clog2(W)-1:0] cfg_sel,
  input  logic [W-1:0]         cfg_word,
  input  logic                 cfg_go,
  output logic                 busy,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [W-1:0]         in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W-1:0]         out_data
);
  localparam int LW = $clog2(W);

  perm_state_e   st;
  logic [LW-1:0] pi, pj, step;
  logic          masks_ok;
  logic [W-1:0]  cw [LW];
  logic [W-1:0]  data_r;
  logic [W-1:0]  op_val, op_msk, grp_res;
  logic          idle, accept;

  perm_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_go    (cfg_go),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .st        (st),
    .pi        (pi),
    .pj        (pj),
    .step      (step),
    .masks_ok  (masks_ok)
  );

  assign idle     = (st == ST_IDLE);
  assign in_ready = idle && masks_ok && !cfg_we && !cfg_go;
  assign accept   = in_valid && in_ready;

  // one shared group unit: conditions masks in PREP, permutes data in RUN
  always_comb begin
    if (st == ST_PREP) begin
      op_val = cw[pi];
      op_msk = cw[pj];
    end else begin
      op_val = data_r;
      op_msk = cw[step];
    end
  end

  grp_unit #(.W(W)) u_grp (
    .val     (op_val),
    .msk     (op_msk),
    .grouped (grp_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LW; k++) cw[k] <= '0;
    end else if (idle && cfg_we && (int'(cfg_sel) < LW)) begin
      cw[cfg_sel] <= cfg_word;
    end else if (st == ST_PREP) begin
      cw[pi] <= grp_res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             data_r <= '0;
    else if (accept)        data_r <= in_data;
    else if (st == ST_RUN)  data_r <= grp_res;
  end

  assign busy      = !idle;
  assign out_valid = (st == ST_OUT);
  assign out_data  = data_r;
endmodule

// File: rtl/perm_engine_chk.sv
module perm_engine_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_we,
  input logic         cfg_go,
  input logic         busy,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  localparam int LW = $clog2(W);

  logic [7:0] lat_cnt;
  logic       lat_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      lat_run <= 1'b0;
    end else if (in_valid && in_ready) begin
      lat_cnt <= '0;
      lat_run <= 1'b1;
    end else if (lat_run && !out_valid) begin
      lat_cnt <= lat_cnt + 1'b1;
    end else if (out_valid) begin
      lat_run <= 1'b0;
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !in_ready));

  assert_go_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_go && !busy) |=> busy);

  assert_ready_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !busy);

  assert_reload_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !busy) |=> !in_ready);

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_run && lat_cnt == 8'(LW)));
endmodule

bind perm_engine perm_engine_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_go    (cfg_go),
  .busy      (busy),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/perm_engine_test.sv
module perm_engine_test;
  localparam int W  = 32;
  localparam int LW = $clog2(W);
  localparam int PREP_CYC = LW * (LW - 1) / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [LW-1:0] cfg_sel = '0;
  logic [W-1:0]  cfg_word = '0;
  logic          cfg_go = 1'b0;
  logic          busy;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  out_data;

  int checks = 0;
  int errors = 0;
  int tgt [W];
  logic [W-1:0] words [LW];

  always #4 clk = ~clk;

  perm_engine #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_word(cfg_word), .cfg_go(cfg_go), .busy(busy), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [W-1:0] d);
    logic [W-1:0] r = '0;
    for (int b = 0; b < W; b++) r[tgt[b]] = d[b];
    return r;
  endfunction

  function automatic logic [W-1:0] grp(input logic [W-1:0] v, input logic [W-1:0] m);
    logic [W-1:0] hi = '0, lo = '0;
    int nh = 0, nl = 0;
    for (int b = 0; b < W; b++) begin
      if (m[b]) begin hi[nh] = v[b]; nh++; end
      else      begin lo[nl] = v[b]; nl++; end
    end
    return (hi << nl) | lo;
  endfunction

  task automatic words_from_tgt();
    for (int k = 0; k < LW; k++)
      for (int b = 0; b < W; b++) words[k][b] = tgt[b][k];
  endtask

  task automatic tgt_from_words();
    for (int b = 0; b < W; b++) begin
      tgt[b] = 0;
      for (int k = 0; k < LW; k++) tgt[b] = tgt[b] | (int'(words[k][b]) << k);
    end
  endtask

  task automatic shuffle();
    for (int b = 0; b < W; b++) tgt[b] = b;
    for (int b = W - 1; b > 0; b--) begin
      int r = int'($urandom_range(b, 0));
      int t = tgt[b];
      tgt[b] = tgt[r];
      tgt[r] = t;
    end
    words_from_tgt();
  endtask

  // write all control words, start conditioning, check its length (R2, R3)
  task automatic load_and_go();
    int n = 0;
    for (int k = 0; k < LW; k++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = LW'(k); cfg_word = words[k];
    end
    @(negedge clk);
    cfg_we = 1'b0; cfg_go = 1'b1;
    @(negedge clk);
    cfg_go = 1'b0;
    while (busy && n < 100) begin
      chk("R3 in_ready low while conditioning", 64'(in_ready), 64'(0));
      n++;
      @(negedge clk);
    end
    chk("R3 conditioning cycles", 64'(n), 64'(PREP_CYC));
    chk("R3 in_ready after conditioning", 64'(in_ready), 64'(1));
  endtask

  // push one word, check latency, hold under back-pressure, single transfer
  task automatic run_word(input logic [W-1:0] d, input logic [W-1:0] exp,
                          input int stall, input string req);
    int n = 0;
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 in_ready low after accept", 64'(in_ready), 64'(0));
    while (!out_valid && n < 50) begin n++; @(negedge clk); end
    chk("R5 latency", 64'(n), 64'(LW));
    chk(req, 64'(out_data), 64'(exp));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R6 hold valid", 64'(out_valid), 64'(1));
      chk("R6 hold data", 64'(out_data), 64'(exp));
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R6 single transfer", 64'(out_valid), 64'(0));
  endtask

  task automatic t_reset();
    chk("R1 busy", 64'(busy), 64'(0));
    chk("R1 in_ready", 64'(in_ready), 64'(0));
    chk("R1 out_valid", 64'(out_valid), 64'(0));
  endtask

  task automatic t_des();
    logic [W-1:0] stage [LW];
    logic [W-1:0] d, e;
    words[0] = 32'h07137FE0; words[1] = 32'h6BD9232C; words[2] = 32'hDD230F1C;
    words[3] = 32'h63665639; words[4] = 32'hA5A435AE;
    stage[0] = 32'h07137FE0; stage[1] = 32'h75196E8C; stage[2] = 32'h56A3CCE4;
    stage[3] = 32'hAA539AC9; stage[4] = 32'h96665A69;
    tgt_from_words();
    load_and_go();
    for (int t = 0; t < 4; t++) begin
      d = (t == 0) ? 32'h0000_0001 : (t == 1) ? 32'h8000_0000 : $urandom;
      e = d;
      for (int k = 0; k < LW; k++) e = grp(e, stage[k]);
      run_word(d, e, t, "R8 known stage masks");
      chk("R4 index model on fixed words", 64'(e), 64'(model(d)));
    end
  endtask

  task automatic t_random();
    logic [W-1:0] d;
    for (int p = 0; p < 6; p++) begin
      shuffle();
      load_and_go();
      for (int t = 0; t < 5; t++) begin
        d = (t == 0) ? 32'hFFFF_0000 : $urandom;
        run_word(d, model(d), t % 3, "R4 random permutation");
      end
    end
  endtask

  task automatic t_ignore_busy();
    logic [W-1:0] d = 32'h1234_5678;
    shuffle();
    // start conditioning, then inject a write and a go mid-way
    for (int k = 0; k < LW; k++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = LW'(k); cfg_word = words[k];
    end
    @(negedge clk);
    cfg_we = 1'b0; cfg_go = 1'b1;
    @(negedge clk);
    cfg_go = 1'b0;
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = '0; cfg_word = 32'hFFFF_FFFF;
    @(negedge clk);
    cfg_we = 1'b0; cfg_go = 1'b1;
    @(negedge clk);
    cfg_go = 1'b0;
    while (busy) @(negedge clk);
    chk("R7 ready after ignored strobes", 64'(in_ready), 64'(1));
    // strobes while a result is computed and held
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = LW'(1); cfg_word = 32'h0;
    @(negedge clk);
    cfg_we = 1'b0; cfg_go = 1'b1;
    @(negedge clk);
    cfg_go = 1'b0;
    while (!out_valid) @(negedge clk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = LW'(2); cfg_word = 32'h0;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R7 held result unaffected", 64'(out_data), 64'(model(d)));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R7 no conditioning after ignored go", 64'(busy), 64'(0));
    run_word(32'hDEAD_BEEF, model(32'hDEAD_BEEF), 1, "R7 later result old permutation");
  endtask

  task automatic t_reload();
    shuffle();
    load_and_go();
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = '0; cfg_word = words[0];
    @(negedge clk);
    cfg_we = 1'b0;
    in_valid = 1'b1; in_data = 32'hA5A5_0F0F;
    for (int c = 0; c < 4; c++) begin
      chk("R9 in_ready low after reload", 64'(in_ready), 64'(0));
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R9 nothing accepted", 64'(busy), 64'(0));
    chk("R9 no output", 64'(out_valid), 64'(0));
    shuffle();
    load_and_go();
    run_word(32'hA5A5_0F0F, model(32'hA5A5_0F0F), 0, "R9 new permutation used");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_des();
    t_random();
    t_ignore_busy();
    t_reload();
    summary();
  end
endmodule